// File: doc/BRIEF.md
# Selectable-Sequence Self-Starting Counter

This block is a four-bit synchronous counter that advances through one of four fixed code sequences on each rising clock edge. The sequence is picked by a two-bit select: a decimal count from 0 to 9, a six-state binary count, a six-state Gray-code count, or an irregular five-state walk. All state bits are loaded together from one next-state function, so there is no ripple between stages.

The counter always starts itself. Any code that does not belong to the active sequence, whether it came from a select change or from an upset, returns to zero on the next enabled edge. No unused code is left as a don't-care. A flag marks the cycle in which the counter sits on the final code of the active sequence. Designers use that flag as a wrap or divide-by-N strobe.

Top module: `seq_select_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes 0 on that edge whatever `en` and `mode` are; reset wins over enable.
- R2: With `rst` low and `en` low, `count` keeps its value across the edge.
- R3: With `mode` = 0 (decimal), enabled edges step 0,1,2,...,9 and then back to 0.
- R4: With `mode` = 1 (six-state binary), enabled edges step 0,1,2,3,4,5 and then back to 0.
- R5: With `mode` = 2 (six-state Gray), enabled edges step 0,1,3,2,6,7 and then back to 0.
- R6: With `mode` = 3 (five-state irregular), enabled edges step 0,1,2,4,6 and then back to 0.
- R7: A `count` value outside the active sequence goes to 0 on the next enabled edge. The values outside are 10-15 for decimal; 6-15 for binary; 4, 5 and 8-15 for Gray; and 3, 5, 7 and 8-15 for irregular.
- R8: A new `mode` value takes effect on the very next edge. A current value that is valid in the new sequence steps to its successor there. A value that is not valid goes to 0.
- R9: `at_last` is high, combinationally from `count` and `mode`, exactly when `count` equals the final code of the selected sequence. That code is 9 for decimal, 5 for binary, 7 for Gray and 6 for irregular.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to zero |
| en | input | 1 | Advance enable; hold when low |
| mode | input | 2 | Sequence select: 0 decimal, 1 binary-6, 2 Gray-6, 3 irregular-5 |
| count | output | 4 | Current counter state |
| at_last | output | 1 | High while `count` is the final code of the selected sequence |

## Verification
The bound checker watches several rules on every clock. It checks that reset clears the count and that a disabled counter holds. It checks that every enabled edge lands on a code valid for the mode that was applied, and that any code outside the sequence collapses to zero. It also checks that the final code always wraps to zero, and that no valid non-final code ever does. The exact order of each sequence is left to the bench's scenarios. So are select changes in mid-count, and the flag tracking a mode change while the count is held. The bench drives the counter only through its ports, so it reaches out-of-sequence codes by switching the select, never by forcing the state.

// File: rtl/seqcnt_pkg.sv
package seqcnt_pkg;

    localparam int CNT_W     = 4;
    localparam int MODE_W    = 2;
    localparam int NUM_MODES = 1 << MODE_W;

    typedef logic [CNT_W-1:0] code_t;

    typedef enum logic [MODE_W-1:0] {
        SEQ_DECADE = 2'd0,
        SEQ_BIN6   = 2'd1,
        SEQ_GRAY6  = 2'd2,
        SEQ_SKIP5  = 2'd3
    } seq_mode_e;

    // One step of a sequence: whether the present code belongs to it,
    // and the code that follows it.
    typedef struct packed {
        logic  valid;
        code_t code;
    } step_t;

    // Final code of each sequence (the one that wraps to zero).
    function automatic code_t last_code(seq_mode_e m);
        code_t r;
        case (m)
            SEQ_DECADE: r = code_t'(9);
            SEQ_BIN6:   r = code_t'(5);
            SEQ_GRAY6:  r = code_t'(7);
            default:    r = code_t'(6);
        endcase
        return r;
    endfunction

    function automatic step_t step_decade(code_t c);
        step_t s;
        s.valid = (c <= code_t'(9));
        s.code  = (c < code_t'(9)) ? c + code_t'(1) : '0;
        return s;
    endfunction

    function automatic step_t step_bin6(code_t c);
        step_t s;
        s.valid = (c <= code_t'(5));
        s.code  = (c < code_t'(5)) ? c + code_t'(1) : '0;
        return s;
    endfunction

    function automatic step_t step_gray6(code_t c);
        step_t s;
        s.valid = 1'b1;
        case (c)
            code_t'(0): s.code = code_t'(1);
            code_t'(1): s.code = code_t'(3);
            code_t'(3): s.code = code_t'(2);
            code_t'(2): s.code = code_t'(6);
            code_t'(6): s.code = code_t'(7);
            code_t'(7): s.code = code_t'(0);
            default: begin
                s.valid = 1'b0;
                s.code  = '0;
            end
        endcase
        return s;
    endfunction

    function automatic step_t step_skip5(code_t c);
        step_t s;
        s.valid = 1'b1;
        case (c)
            code_t'(0): s.code = code_t'(1);
            code_t'(1): s.code = code_t'(2);
            code_t'(2): s.code = code_t'(4);
            code_t'(4): s.code = code_t'(6);
            code_t'(6): s.code = code_t'(0);
            default: begin
                s.valid = 1'b0;
                s.code  = '0;
            end
        endcase
        return s;
    endfunction

    function automatic step_t seq_step(seq_mode_e m, code_t c);
        step_t s;
        case (m)
            SEQ_DECADE: s = step_decade(c);
            SEQ_BIN6:   s = step_bin6(c);
            SEQ_GRAY6:  s = step_gray6(c);
            default:    s = step_skip5(c);
        endcase
        return s;
    endfunction

    function automatic logic code_valid(seq_mode_e m, code_t c);
        step_t s;
        s = seq_step(m, c);
        return s.valid;
    endfunction

endpackage

// File: rtl/seqcnt_next.sv
module seqcnt_next
    import seqcnt_pkg::*;
(
    input  code_t     cur,
    input  seq_mode_e mode,
    output code_t     nxt
);

    step_t cand [NUM_MODES];

    // One successor table per sequence, all evaluated in parallel.
    generate
        for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
            assign cand[m] = seq_step(seq_mode_e'(MODE_W'(m)), cur);
        end
    endgenerate

    step_t sel;

    always_comb begin
        sel = cand[mode];
        // A code outside the selected sequence always recovers to zero.
        nxt = sel.valid ? sel.code : '0;
    end

endmodule

// File: rtl/seqcnt_term.sv
module seqcnt_term
    import seqcnt_pkg::*;
(
    input  code_t     cur,
    input  seq_mode_e mode,
    output logic      at_last
);

    always_comb begin
        at_last = (cur == last_code(mode));
    end

endmodule

// File: rtl/seqcnt_reg.sv
module seqcnt_reg
    import seqcnt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  code_t d,
    output code_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/seq_select_counter.sv
module seq_select_counter
    import seqcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [MODE_W-1:0] mode,
    output logic [CNT_W-1:0]  count,
    output logic              at_last
);

    seq_mode_e mode_e;
    code_t     state_q;
    code_t     state_d;

    assign mode_e = seq_mode_e'(mode);

    seqcnt_next u_next (
        .cur  (state_q),
        .mode (mode_e),
        .nxt  (state_d)
    );

    seqcnt_reg u_reg (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .d   (state_d),
        .q   (state_q)
    );

    seqcnt_term u_term (
        .cur     (state_q),
        .mode    (mode_e),
        .at_last (at_last)
    );

    assign count = state_q;

endmodule

// File: rtl/seqcnt_chk.sv
module seqcnt_chk
    import seqcnt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [MODE_W-1:0] mode,
    input logic [CNT_W-1:0]  count,
    input logic              at_last
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (count == '0)); // R1

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count)); // R2

    AST_LAST_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (en && at_last) |=> (count == '0)); // R3

    AST_MID_NOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (en && !at_last && code_valid(seq_mode_e'(mode), count)) |=> (count != '0)); // R6

    AST_STRAY_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (en && !code_valid(seq_mode_e'(mode), count)) |=> (count == '0)); // R7

    AST_LANDS_VALID: assert property (@(posedge clk) disable iff (rst)
        en |=> code_valid(seq_mode_e'($past(mode)), count)); // R8

    AST_FLAG_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
        at_last |-> code_valid(seq_mode_e'(mode), count)); // R9

endmodule

bind seq_select_counter seqcnt_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .mode    (mode),
    .count   (count),
    .at_last (at_last)
);

// File: tb/sim_seq_select_counter.sv
module sim_seq_select_counter;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 60;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [3:0] count;
    logic       at_last;

    int checks = 0;
    int errors = 0;

    seq_select_counter u0 (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .mode    (mode),
        .count   (count),
        .at_last (at_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Row: {rst, en, mode[1:0], expected count[3:0], expected at_last}
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b1,1'b0,2'd0,4'd0,1'b0},
        // decimal run
        {1'b0,1'b1,2'd0,4'd1,1'b0}, {1'b0,1'b1,2'd0,4'd2,1'b0},
        {1'b0,1'b1,2'd0,4'd3,1'b0}, {1'b0,1'b1,2'd0,4'd4,1'b0},
        {1'b0,1'b1,2'd0,4'd5,1'b0}, {1'b0,1'b1,2'd0,4'd6,1'b0},
        {1'b0,1'b1,2'd0,4'd7,1'b0}, {1'b0,1'b1,2'd0,4'd8,1'b0},
        {1'b0,1'b1,2'd0,4'd9,1'b1}, {1'b0,1'b1,2'd0,4'd0,1'b0},
        // binary-6 run
        {1'b0,1'b1,2'd1,4'd1,1'b0}, {1'b0,1'b1,2'd1,4'd2,1'b0},
        {1'b0,1'b1,2'd1,4'd3,1'b0}, {1'b0,1'b1,2'd1,4'd4,1'b0},
        {1'b0,1'b1,2'd1,4'd5,1'b1}, {1'b0,1'b1,2'd1,4'd0,1'b0},
        // Gray-6 run
        {1'b0,1'b1,2'd2,4'd1,1'b0}, {1'b0,1'b1,2'd2,4'd3,1'b0},
        {1'b0,1'b1,2'd2,4'd2,1'b0}, {1'b0,1'b1,2'd2,4'd6,1'b0},
        {1'b0,1'b1,2'd2,4'd7,1'b1}, {1'b0,1'b1,2'd2,4'd0,1'b0},
        // irregular-5 run
        {1'b0,1'b1,2'd3,4'd1,1'b0}, {1'b0,1'b1,2'd3,4'd2,1'b0},
        {1'b0,1'b1,2'd3,4'd4,1'b0}, {1'b0,1'b1,2'd3,4'd6,1'b1},
        {1'b0,1'b1,2'd3,4'd0,1'b0},
        // hold
        {1'b0,1'b0,2'd3,4'd0,1'b0}, {1'b0,1'b1,2'd3,4'd1,1'b0},
        {1'b0,1'b0,2'd3,4'd1,1'b0},
        // select changes
        {1'b0,1'b1,2'd2,4'd3,1'b0}, {1'b0,1'b1,2'd3,4'd0,1'b0},
        {1'b0,1'b1,2'd0,4'd1,1'b0}, {1'b0,1'b1,2'd0,4'd2,1'b0},
        {1'b0,1'b1,2'd0,4'd3,1'b0}, {1'b0,1'b1,2'd0,4'd4,1'b0},
        {1'b0,1'b1,2'd0,4'd5,1'b0}, {1'b0,1'b1,2'd3,4'd0,1'b0},
        {1'b0,1'b1,2'd1,4'd1,1'b0}, {1'b0,1'b1,2'd1,4'd2,1'b0},
        {1'b0,1'b1,2'd1,4'd3,1'b0}, {1'b0,1'b1,2'd1,4'd4,1'b0},
        {1'b0,1'b1,2'd2,4'd0,1'b0},
        {1'b0,1'b1,2'd2,4'd1,1'b0}, {1'b0,1'b1,2'd2,4'd3,1'b0},
        {1'b0,1'b1,2'd2,4'd2,1'b0}, {1'b0,1'b1,2'd2,4'd6,1'b0},
        {1'b0,1'b1,2'd2,4'd7,1'b1}, {1'b0,1'b1,2'd3,4'd0,1'b0},
        {1'b0,1'b1,2'd3,4'd1,1'b0}, {1'b0,1'b1,2'd3,4'd2,1'b0},
        {1'b0,1'b1,2'd3,4'd4,1'b0}, {1'b0,1'b1,2'd3,4'd6,1'b1},
        // flag follows the select while the count holds at 6
        {1'b0,1'b0,2'd0,4'd6,1'b0}, {1'b0,1'b0,2'd1,4'd6,1'b0},
        {1'b0,1'b0,2'd2,4'd6,1'b0}, {1'b0,1'b0,2'd3,4'd6,1'b1},
        {1'b0,1'b1,2'd0,4'd7,1'b0}, {1'b0,1'b1,2'd1,4'd0,1'b0}
    };

    function automatic string row_req(int i);
        if (i == 0)  return "R1";
        if (i <= 10) return "R3";
        if (i <= 16) return "R4";
        if (i <= 22) return "R5";
        if (i <= 27) return "R6";
        if (i <= 30) return "R2";
        if (i == 31) return "R8";
        if (i == 32) return "R7";
        if (i <= 37) return "R8";
        if (i == 38) return "R7";
        if (i <= 42) return "R8";
        if (i == 43) return "R7";
        if (i <= 48) return "R5";
        if (i == 49) return "R7";
        if (i <= 53) return "R6";
        if (i <= 57) return "R9";
        if (i == 58) return "R8";
        return "R7";
    endfunction

    task automatic check(string req, logic [3:0] exp_cnt, logic exp_last);
        checks++;
        if (count !== exp_cnt || at_last !== exp_last) begin
            errors++;
            $display("FAIL %s: count=%0d at_last=%0b expected count=%0d at_last=%0b",
                     req, count, at_last, exp_cnt, exp_last);
        end
    endtask

    task automatic step(logic r, logic e, logic [1:0] m);
        rst  = r;
        en   = e;
        mode = m;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2;
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][8], VEC[i][7], VEC[i][6:5]);
            check(row_req(i), VEC[i][4:1], VEC[i][0]);
        end

        // R1: reset wins over enable in mid-count
        step(1'b0, 1'b1, 2'd0);
        step(1'b0, 1'b1, 2'd0);
        check("R1", 4'd2, 1'b0);
        step(1'b1, 1'b1, 2'd0);
        check("R1", 4'd0, 1'b0);

        // R7: decimal final code 9 is outside binary-6
        for (int k = 0; k < 9; k++) step(1'b0, 1'b1, 2'd0);
        check("R3", 4'd9, 1'b1);
        step(1'b0, 1'b1, 2'd1);
        check("R7", 4'd0, 1'b0);

        // R2: long hold keeps the value
        step(1'b0, 1'b1, 2'd2);
        step(1'b0, 1'b1, 2'd2);
        for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 2'd2);
        check("R2", 4'd3, 1'b0);

        // R1: reset with enable low
        step(1'b1, 1'b0, 2'd2);
        check("R1", 4'd0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule